// File: doc/BRIEF.md
# Fuse Array Controller

This block puts a one-time-programmable fuse array behind a small word-addressed register file. The array holds 8 banks of 256 rows, each row one byte wide, and is modelled inside the block by a register array. A host uses single-cycle read and write strobes, a 12-bit word address and 32-bit data. It loads a packed fuse location into two address registers and starts either an explicit sense cycle or a single-bit program cycle. It then polls a busy flag and collects done and error flags.

Every row also has a shadow copy, visible as its own word in a window that follows the control registers. Shadow reads can be refused for read-locked banks and shadow writes for override-locked banks. Each refusal raises its own error flag. Programming blows a fuse only when a key register holds the unlock value and the bank is not program-locked. Bank locks, the key value and the cycle length are parameters.

Top module: `fuse_ctrl_regs`

## Requirements
- R1: After reset every control register reads 0 and every fuse cell and shadow row reads 0. Read data appears on `bus_rdata` the cycle after the read strobe.
- R2: The word map is: status 0, status mask 1, error 2, error mask 3, fuse control 4, upper address 5, lower address 6, sense data 7, program key 8. The shadow row of bank b, row r is at word 16 + 256*b + r. All other words read 0.
- R3: Status bit 7 is busy. It reads 1 for exactly CYCLE_LEN cycles, starting in the cycle after the fuse control write that starts a cycle.
- R4: Writing fuse control with bit 3 set (and bit 0 clear) while idle starts a sense cycle. When it ends, the addressed row's fuse value is placed in the sense data register and status bit 0 (sense done) is set.
- R5: Writing fuse control with bit 0 set while idle starts a program cycle. When it ends, the addressed bit is ORed into the fuse row and into its shadow row, and status bit 1 (program done) is set. A fuse that is already blown is never cleared.
- R6: A program request made while the key register is not 0xAA, or while the addressed bank is program-locked (default: bank 5), does not start a cycle. Busy stays 0, error bit 6 (write protect) is set, program done is not set and the fuse is unchanged.
- R7: The upper address register holds the bank in bits 5:3 and row bits 7:5 in bits 2:0. The lower address register holds row bits 4:0 in bits 7:3 and the bit index in bits 2:0.
- R8: A shadow word reads the row in bits 7:0, with zeros above. A write to a shadow word of a bank that is not override-locked replaces the row with write data bits 7:0.
- R9: Reading a shadow word of a read-locked bank (default: bank 7) returns 0 and sets error bit 4.
- R10: Writing a shadow word of an override-locked bank (default: bank 6) leaves the row unchanged and sets error bit 5.
- R11: Status bits 1:0 and the error register clear only where a 1 is written. Writing a 0 bit leaves that flag set.
- R12: While busy, fuse control reads bit 3 for a sense cycle or bit 0 for a program cycle, and 0 when idle. Writes to fuse control during a cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 12 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the read strobe |

## Verification
The checks assume the host raises at most one of the two strobes in a cycle. They also assume the host does not change the address registers in the same cycle as the fuse control write that starts an operation. The bench drives every access as a separate one-cycle strobe with both strobes never high together. It writes the location and the key in earlier accesses than the start command. It reaches locked banks, rows above 31 and wrong keys both through directed cases and through seeded random operations.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    localparam int BANK_W   = 3;
    localparam int ROW_W    = 8;
    localparam int ROW_HI_W = 3;
    localparam int ROW_LO_W = ROW_W - ROW_HI_W;
    localparam int BIT_W    = 3;
    localparam int CELL_W   = 1 << BIT_W;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 12;
    localparam int HI_W     = BANK_W + ROW_HI_W;
    localparam int NBANK    = 1 << BANK_W;
    localparam int NROW     = 1 << ROW_W;
    localparam int NCELL    = NBANK * NROW;
    localparam int IDX_W    = BANK_W + ROW_W;

    // word map
    localparam logic [ADDR_W-1:0] A_STAT     = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STAT_EN  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_FAULT    = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_FAULT_EN = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_CMD      = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_HI       = ADDR_W'(5);
    localparam logic [ADDR_W-1:0] A_LO       = ADDR_W'(6);
    localparam logic [ADDR_W-1:0] A_SDAT     = ADDR_W'(7);
    localparam logic [ADDR_W-1:0] A_KEY      = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] A_WIN      = ADDR_W'(16);
    localparam logic [ADDR_W-1:0] A_WIN_END  = ADDR_W'(16 + NCELL);

    // flag positions
    localparam int ST_BUSY  = 7;
    localparam int ST_PDONE = 1;
    localparam int ST_SDONE = 0;
    localparam int ER_PROG  = 7;
    localparam int ER_WP    = 6;
    localparam int ER_OVR   = 5;
    localparam int ER_RD    = 4;
    localparam int CMD_PRG  = 0;
    localparam int CMD_SNS  = 3;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_SENSE = 2'd1,
        OP_PROG  = 2'd2
    } op_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [BIT_W-1:0]  bsel;
    } loc_t;

    typedef struct packed {
        logic stat;
        logic stat_en;
        logic fault;
        logic fault_en;
        logic cmd;
        logic hi;
        logic lo;
        logic sdat;
        logic key;
        logic win;
    } hit_t;

    function automatic loc_t loc_unpack(input logic [HI_W-1:0] hi, input logic [CELL_W-1:0] lo);
        loc_t l;
        l.bank = hi[HI_W-1 -: BANK_W];
        l.row  = {hi[ROW_HI_W-1:0], lo[CELL_W-1 -: ROW_LO_W]};
        l.bsel = lo[BIT_W-1:0];
        return l;
    endfunction

    function automatic logic [IDX_W-1:0] cell_idx(input loc_t l);
        return {l.bank, l.row};
    endfunction

    function automatic logic [CELL_W-1:0] bit_mask(input logic [BIT_W-1:0] b);
        return CELL_W'(1) << b;
    endfunction

    function automatic logic [DATA_W-1:0] zext(input logic [CELL_W-1:0] v);
        return DATA_W'(v);
    endfunction

endpackage

// File: rtl/fuse_dec.sv
module fuse_dec
    import fuse_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output hit_t              hit,
    output logic [IDX_W-1:0]  win_idx
);
    logic [ADDR_W-1:0] win_off;

    always_comb begin
        hit          = '0;
        hit.stat     = (addr == A_STAT);
        hit.stat_en  = (addr == A_STAT_EN);
        hit.fault    = (addr == A_FAULT);
        hit.fault_en = (addr == A_FAULT_EN);
        hit.cmd      = (addr == A_CMD);
        hit.hi       = (addr == A_HI);
        hit.lo       = (addr == A_LO);
        hit.sdat     = (addr == A_SDAT);
        hit.key      = (addr == A_KEY);
        hit.win      = (addr >= A_WIN) && (addr < A_WIN_END);
    end

    assign win_off = addr - A_WIN;
    assign win_idx = win_off[IDX_W-1:0];

    logic unused_dec;
    assign unused_dec = ^win_off[ADDR_W-1:IDX_W];

endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
    import fuse_pkg::*;
#(
    parameter int CYCLE_LEN = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic go_sense,
    input  logic go_prog,
    input  loc_t go_loc,
    output logic busy,
    output op_e  run_op,
    output loc_t run_loc,
    output logic fin
);
    localparam int CNT_W = (CYCLE_LEN > 2) ? $clog2(CYCLE_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CYCLE_LEN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    op_e              op_q;
    loc_t             loc_q;

    assign fin     = busy_q && (cnt_q == '0);
    assign busy    = busy_q;
    assign run_op  = op_q;
    assign run_loc = loc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            op_q   <= OP_NONE;
            loc_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (go_prog || go_sense) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_LOAD;
            op_q   <= go_prog ? OP_PROG : OP_SENSE;
            loc_q  <= go_loc;
        end
    end

endmodule

// File: rtl/fuse_store.sv
module fuse_store
    import fuse_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  sns_idx,
    output logic [CELL_W-1:0] sns_data,
    input  logic              blow_en,
    input  logic [IDX_W-1:0]  blow_idx,
    input  logic [CELL_W-1:0] blow_mask,
    input  logic [IDX_W-1:0]  sh_idx,
    output logic [CELL_W-1:0] sh_rdata,
    input  logic              sh_we,
    input  logic [CELL_W-1:0] sh_wdata
);
    logic [CELL_W-1:0] cells_q  [NCELL];
    logic [CELL_W-1:0] shadow_q [NCELL];

    assign sns_data = cells_q[sns_idx];
    assign sh_rdata = shadow_q[sh_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCELL; i++) begin
                cells_q[i]  <= '0;
                shadow_q[i] <= '0;
            end
        end else begin
            if (blow_en) begin
                cells_q[blow_idx] <= cells_q[blow_idx] | blow_mask;
            end
            if (sh_we && blow_en && (sh_idx == blow_idx)) begin
                shadow_q[sh_idx] <= sh_wdata | blow_mask;
            end else begin
                if (sh_we) begin
                    shadow_q[sh_idx] <= sh_wdata;
                end
                if (blow_en) begin
                    shadow_q[blow_idx] <= shadow_q[blow_idx] | blow_mask;
                end
            end
        end
    end

endmodule

// File: rtl/fuse_ctrl_regs.sv
module fuse_ctrl_regs
    import fuse_pkg::*;
#(
    parameter int               CYCLE_LEN  = 6,
    parameter logic [7:0]       PROG_KEY   = 8'hAA,
    parameter logic [NBANK-1:0] RD_LOCK    = 8'h80,
    parameter logic [NBANK-1:0] OVR_LOCK   = 8'h40,
    parameter logic [NBANK-1:0] PRG_LOCK   = 8'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    hit_t              hit;
    logic [IDX_W-1:0]  win_idx;
    logic [BANK_W-1:0] win_bank;

    logic [1:0]        stat_q;
    logic [7:0]        stat_en_q;
    logic [7:0]        err_q;
    logic [7:0]        err_en_q;
    logic [HI_W-1:0]   hi_q;
    logic [CELL_W-1:0] lo_q;
    logic [CELL_W-1:0] sdat_q;
    logic [7:0]        key_q;
    logic [DATA_W-1:0] rdata_q;

    logic              busy, fin;
    op_e               run_op;
    loc_t              run_loc, cur_loc;
    logic              cmd_wr, prog_req, sense_req, prog_block;
    logic              go_prog, go_sense, wp_err;
    logic              win_rd, win_wr, win_rd_lock, win_wr_lock;
    logic [CELL_W-1:0] sns_data, sh_rdata;
    logic              blow_en;
    logic [DATA_W-1:0] rd_mux;
    logic [7:0]        cmd_view;

    fuse_dec u_dec (
        .addr    (bus_addr),
        .hit     (hit),
        .win_idx (win_idx)
    );

    assign win_bank = win_idx[IDX_W-1 -: BANK_W];
    assign cur_loc  = loc_unpack(hi_q, lo_q);

    // command acceptance
    assign cmd_wr     = bus_wr && hit.cmd && !busy;
    assign prog_req   = cmd_wr && bus_wdata[CMD_PRG];
    assign sense_req  = cmd_wr && bus_wdata[CMD_SNS] && !bus_wdata[CMD_PRG];
    assign prog_block = (key_q != PROG_KEY) || PRG_LOCK[cur_loc.bank];
    assign go_prog    = prog_req && !prog_block;
    assign go_sense   = sense_req;
    assign wp_err     = prog_req && prog_block;

    // shadow window accesses
    assign win_rd      = bus_rd && hit.win;
    assign win_wr      = bus_wr && hit.win;
    assign win_rd_lock = win_rd && RD_LOCK[win_bank];
    assign win_wr_lock = win_wr && OVR_LOCK[win_bank];

    fuse_seq #(.CYCLE_LEN(CYCLE_LEN)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .go_sense (go_sense),
        .go_prog  (go_prog),
        .go_loc   (cur_loc),
        .busy     (busy),
        .run_op   (run_op),
        .run_loc  (run_loc),
        .fin      (fin)
    );

    assign blow_en = fin && (run_op == OP_PROG);

    fuse_store u_store (
        .clk       (clk),
        .rst       (rst),
        .sns_idx   (cell_idx(run_loc)),
        .sns_data  (sns_data),
        .blow_en   (blow_en),
        .blow_idx  (cell_idx(run_loc)),
        .blow_mask (bit_mask(run_loc.bsel)),
        .sh_idx    (win_idx),
        .sh_rdata  (sh_rdata),
        .sh_we     (win_wr && !OVR_LOCK[win_bank]),
        .sh_wdata  (bus_wdata[CELL_W-1:0])
    );

    // control registers
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q    <= '0;
            stat_en_q <= '0;
            err_q     <= '0;
            err_en_q  <= '0;
            hi_q      <= '0;
            lo_q      <= '0;
            sdat_q    <= '0;
            key_q     <= '0;
        end else begin
            logic [1:0] st_n;
            logic [7:0] er_n;
            st_n = stat_q;
            er_n = err_q;
            if (bus_wr && hit.stat)  st_n = st_n & ~bus_wdata[1:0];
            if (bus_wr && hit.fault) er_n = er_n & ~bus_wdata[7:0];
            if (fin && run_op == OP_SENSE) st_n[ST_SDONE] = 1'b1;
            if (blow_en)                   st_n[ST_PDONE] = 1'b1;
            if (wp_err)      er_n[ER_WP]  = 1'b1;
            if (win_rd_lock) er_n[ER_RD]  = 1'b1;
            if (win_wr_lock) er_n[ER_OVR] = 1'b1;
            stat_q <= st_n;
            err_q  <= er_n;
            if (bus_wr && hit.stat_en)  stat_en_q <= bus_wdata[7:0];
            if (bus_wr && hit.fault_en) err_en_q  <= bus_wdata[7:0];
            if (bus_wr && hit.hi)       hi_q      <= bus_wdata[HI_W-1:0];
            if (bus_wr && hit.lo)       lo_q      <= bus_wdata[CELL_W-1:0];
            if (bus_wr && hit.key)      key_q     <= bus_wdata[7:0];
            if (fin && run_op == OP_SENSE) sdat_q <= sns_data;
        end
    end

    // read path
    always_comb begin
        cmd_view          = '0;
        cmd_view[CMD_SNS] = busy && (run_op == OP_SENSE);
        cmd_view[CMD_PRG] = busy && (run_op == OP_PROG);
    end

    always_comb begin
        rd_mux = '0;
        unique case (1'b1)
            hit.stat:     rd_mux = zext({busy, 5'b0, stat_q});
            hit.stat_en:  rd_mux = zext(stat_en_q);
            hit.fault:    rd_mux = zext(err_q);
            hit.fault_en: rd_mux = zext(err_en_q);
            hit.cmd:      rd_mux = zext(cmd_view);
            hit.hi:       rd_mux = zext(CELL_W'(hi_q));
            hit.lo:       rd_mux = zext(lo_q);
            hit.sdat:     rd_mux = zext(sdat_q);
            hit.key:      rd_mux = zext(key_q);
            hit.win:      rd_mux = RD_LOCK[win_bank] ? '0 : zext(sh_rdata);
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata = rdata_q;

    logic unused_top;
    assign unused_top = ^bus_wdata[DATA_W-1:8];

endmodule

// File: rtl/fuse_ctrl_chk.sv
module fuse_ctrl_chk
    import fuse_pkg::*;
#(
    parameter int         CYCLE_LEN = 6,
    parameter logic [7:0] PROG_KEY  = 8'hAA
) (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       fin,
    input logic       prog_req,
    input logic       win_rd_lock,
    input op_e        run_op,
    input loc_t       run_loc,
    input logic [7:0] key_q,
    input logic [7:0] err_q,
    input logic [1:0] stat_q
);
    logic [15:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) run_cnt <= '0;
        else     run_cnt <= busy ? run_cnt + 16'd1 : 16'd0;
    end

    // R3
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> run_cnt == 16'(CYCLE_LEN));

    // R4
    sense_done_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && $past(run_op) == OP_SENSE) |-> stat_q[ST_SDONE]);

    // R5
    prog_done_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && $past(run_op) == OP_PROG) |-> stat_q[ST_PDONE]);

    // R6
    key_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (prog_req && key_q != PROG_KEY) |=> (!busy && err_q[ER_WP]));

    // R12
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !fin) |=> ($stable(run_op) && $stable(run_loc) && busy));

    // R9
    rd_lock_chk: assert property (@(posedge clk) disable iff (rst)
        win_rd_lock |=> err_q[ER_RD]);

endmodule

bind fuse_ctrl_regs fuse_ctrl_chk #(
    .CYCLE_LEN (CYCLE_LEN),
    .PROG_KEY  (PROG_KEY)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .fin         (fin),
    .prog_req    (prog_req),
    .win_rd_lock (win_rd_lock),
    .run_op      (run_op),
    .run_loc     (run_loc),
    .key_q       (key_q),
    .err_q       (err_q),
    .stat_q      (stat_q)
);

// File: tb/sim_fuse_ctrl_regs.sv
module sim_fuse_ctrl_regs;

    localparam int L = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int nchk = 0;
    int nerr = 0;
    bit ended = 0;
    logic [7:0] m_fuse [2048];
    logic [7:0] m_sh   [2048];

    fuse_ctrl_regs #(.CYCLE_LEN(L)) u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (wr),
        .bus_rd    (rd),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all bus tasks start and end at a falling edge
    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    function automatic logic [11:0] win_addr(input int b, input int r);
        return 12'(16 + b * 256 + r);
    endfunction

    task automatic set_loc(input int b, input int r, input int bt);
        wr_reg(12'd5, 32'((b << 3) | (r >> 5)));
        wr_reg(12'd6, 32'(((r << 3) | bt) & 255));
    endtask

    task automatic clear_flags();
        wr_reg(12'd0, 32'hFF);
        wr_reg(12'd2, 32'hFF);
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] v;
        int n = 0;
        rd_reg(12'd0, v);
        while (v[7] && n < 40) begin
            rd_reg(12'd0, v);
            n++;
        end
        if (v[7]) chk(tag, v, 32'h0);
    endtask

    task automatic do_sense(input int b, input int r, input string tag);
        logic [31:0] v;
        set_loc(b, r, 0);
        clear_flags();
        wr_reg(12'd4, 32'h08);
        wait_idle(tag);
        rd_reg(12'd0, v); chk({tag, " R4 status"}, v, 32'h01);
        rd_reg(12'd7, v); chk({tag, " R4 sense data"}, v, 32'(m_fuse[b*256+r]));
    endtask

    task automatic do_prog(input int b, input int r, input int bt, input logic [7:0] key, input string tag);
        logic [31:0] v;
        wr_reg(12'd8, 32'(key));
        set_loc(b, r, bt);
        clear_flags();
        wr_reg(12'd4, 32'h01);
        if (key != 8'hAA || b == 5) begin
            rd_reg(12'd0, v); chk({tag, " R6 status"}, v, 32'h00);
            rd_reg(12'd2, v); chk({tag, " R6 error"}, v, 32'h40);
        end else begin
            wait_idle(tag);
            m_fuse[b*256+r] = m_fuse[b*256+r] | (8'd1 << bt);
            m_sh[b*256+r]   = m_sh[b*256+r]   | (8'd1 << bt);
            rd_reg(12'd0, v); chk({tag, " R5 status"}, v, 32'h02);
            rd_reg(12'd2, v); chk({tag, " R5 error"}, v, 32'h00);
        end
    endtask

    task automatic sh_read(input int b, input int r, input string tag);
        logic [31:0] v;
        clear_flags();
        rd_reg(win_addr(b, r), v);
        if (b == 7) begin
            chk({tag, " R9 data"}, v, 32'h0);
            rd_reg(12'd2, v); chk({tag, " R9 error"}, v, 32'h10);
        end else begin
            chk({tag, " R8 data"}, v, 32'(m_sh[b*256+r]));
            rd_reg(12'd2, v); chk({tag, " R8 error"}, v, 32'h00);
        end
    endtask

    task automatic sh_write(input int b, input int r, input logic [31:0] d, input string tag);
        logic [31:0] v;
        clear_flags();
        wr_reg(win_addr(b, r), d);
        if (b == 6) begin
            rd_reg(12'd2, v); chk({tag, " R10 error"}, v, 32'h20);
        end else begin
            m_sh[b*256+r] = d[7:0];
            rd_reg(12'd2, v); chk({tag, " R8 error"}, v, 32'h00);
        end
        if (b != 7) begin
            rd_reg(win_addr(b, r), v); chk({tag, " R8/R10 readback"}, v, 32'(m_sh[b*256+r]));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            nchk++; nerr++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5EED));
        for (int i = 0; i < 2048; i++) begin
            m_fuse[i] = 8'h00;
            m_sh[i]   = 8'h00;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R2: reset values across the map
        for (int a = 0; a < 9; a++) begin
            rd_reg(12'(a), v); chk("R1 reset register", v, 32'h0);
        end
        rd_reg(win_addr(2, 200), v); chk("R1 reset shadow", v, 32'h0);
        rd_reg(12'd12, v); chk("R2 hole reads zero", v, 32'h0);
        wr_reg(12'd1, 32'h1234_5603); rd_reg(12'd1, v); chk("R2 status mask", v, 32'h03);
        wr_reg(12'd3, 32'hFFFF_FF5A); rd_reg(12'd3, v); chk("R2 error mask", v, 32'h5A);

        // R3 / R12: exact busy window and control readback
        set_loc(1, 40, 0);
        clear_flags();
        wr_reg(12'd4, 32'h08);
        rd_reg(12'd4, v); chk("R12 control during sense", v, 32'h08);
        wr_reg(12'd4, 32'h01); // ignored while busy
        repeat (L - 3) @(negedge clk);
        rd_reg(12'd0, v); chk("R3 busy last cycle", v & 32'h80, 32'h80);
        rd_reg(12'd0, v); chk("R3 idle after window", v, 32'h01);
        rd_reg(12'd4, v); chk("R12 control idle", v, 32'h00);
        rd_reg(12'd7, v); chk("R12 ignored write left fuse", v, 32'h00);

        // R11: write-one-to-clear
        wr_reg(12'd0, 32'h02); rd_reg(12'd0, v); chk("R11 zero leaves flag", v, 32'h01);
        wr_reg(12'd0, 32'h01); rd_reg(12'd0, v); chk("R11 one clears flag", v, 32'h00);
        rd_reg(win_addr(7, 3), v);
        wr_reg(win_addr(6, 3), 32'h77);
        rd_reg(12'd2, v); chk("R11 both errors", v, 32'h30);
        wr_reg(12'd2, 32'h10); rd_reg(12'd2, v); chk("R11 partial clear", v, 32'h20);

        // R7: packing with high row bits, R5 never clears
        do_prog(3, 8'hA7, 5, 8'hAA, "R7 pack");
        rd_reg(win_addr(3, 8'hA7), v); chk("R7 shadow of programmed row", v, 32'h20);
        do_sense(3, 8'h27, "R7 alias row");
        do_prog(3, 8'hA7, 0, 8'hAA, "R5 second bit");
        do_prog(3, 8'hA7, 5, 8'hAA, "R5 reblow");
        do_sense(3, 8'hA7, "R5 no clear");
        chk("R5 model row", 32'(m_fuse[3*256+8'hA7]), 32'h21);

        // R6: wrong key and locked bank
        do_prog(2, 9, 1, 8'h55, "R6 wrong key");
        do_prog(5, 9, 1, 8'hAA, "R6 locked bank");
        do_sense(2, 9, "R6 fuse untouched");

        // R8 / R9 / R10 directed
        sh_write(0, 255, 32'hDEAD_BEC3, "R8 top row");
        sh_read(0, 255, "R8 top row");
        sh_write(6, 17, 32'h0000_00FF, "R10 locked");
        sh_read(7, 0, "R9 locked");

        // seeded random mix
        for (int it = 0; it < 300; it++) begin
            int b = int'($urandom % 8);
            int r = int'($urandom % 256);
            int bt = int'($urandom % 8);
            int op = int'($urandom % 5);
            logic [7:0] k;
            case (op)
                0: do_sense(b, r, "rand sense");
                1: do_prog(b, r, bt, 8'hAA, "rand prog");
                2: begin
                    k = 8'($urandom);
                    if (k == 8'hAA) k = 8'h5A;
                    do_prog(b, r, bt, k, "rand badkey");
                end
                3: sh_read(b, r, "rand shread");
                default: sh_write(b, r, $urandom, "rand shwrite");
            endcase
        end

        ended = 1;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule